// File: doc/BRIEF.md
# Audio-Unit Register Read Decoder

This block sits on the read path of a console processor that has an audio unit built into the same die. Three address sources share one internal address bus: the processor core, an object-attribute DMA engine and a sample-fetch DMA engine. Two grant inputs choose which of them owns the bus in a given cycle.

For each bus cycle the block decides whether an on-chip register read takes place, pulses the clock strobe of either joypad port, and decides whether the internal data bus is cut off from the external data bus. It also steers the returned byte and keeps a latch of the last value seen on the external bus, which later open-bus reads return.

The gate that allows a register read looks only at the core's own address. The register index, however, is taken from the multiplexed internal bus. As a result, a DMA cycle can trigger a register read or a joypad clock while the core is addressing the register window. The same DMA cycle is blocked from doing so while the core is elsewhere.

Every port is a plain per-cycle bus signal. One bus cycle is presented per clock, so there is no valid/ready handshake and no back-pressure. All outputs except the open-bus latch follow the inputs within the same cycle.

Top module: `apu_rd_decode`

## Requirements
- R1: `int_addr` equals `dmc_addr` when `dmc_gnt` is 1. Otherwise it equals `oam_addr` when `oam_gnt` is 1. Otherwise it equals `core_addr`.
- R2: The read gate is open only when `bus_rd` is 1 and `core_addr[15:5]` equals 11'h200 (window $4000–$401F). While the gate is closed, `reg_read`, `isolate`, `bus_conflict`, `pad1_clk` and `pad2_clk` are all 0, whatever the internal address is.
- R3: While the gate is open, the register index is `int_addr[4:0]`, not `core_addr[4:0]`. A DMA address in the $40xx page can therefore select a register.
- R4: With the gate open, index 5'h16 raises `pad1_clk` and index 5'h17 raises `pad2_clk` in the same cycle. At most one strobe is high at any time.
- R5: With the gate open, `isolate` is 1 when the index is 5'h15 or `test_en` is 1. `rd_data` is then the matching register: index 5'h15 gives `status_data`, 5'h16 gives `pad1_data`, 5'h17 gives `pad2_data`, and any other index gives `test_data`.
- R6: With the gate open, `test_en` at 0 and index 5'h16 or 5'h17, `bus_conflict` is 1, `isolate` is 0, and `rd_data` is the bitwise AND of `ext_data` with the data of the selected joypad.
- R7: When neither isolation nor a conflict applies, `rd_data` equals `ext_data`.
- R8: `open_bus` is 0 after reset. It captures `ext_data` at the clock edge ending every read cycle that is not isolated. It holds its value across isolated reads and across non-read cycles.
- R9: `reg_read` is 1 exactly when `isolate` or `bus_conflict` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Current cycle is a read |
| core_addr | input | 16 | Core address bus |
| oam_gnt | input | 1 | Object DMA owns the internal bus |
| oam_addr | input | 16 | Object DMA address |
| dmc_gnt | input | 1 | Sample DMA owns the internal bus |
| dmc_addr | input | 16 | Sample DMA address |
| test_en | input | 1 | Test mode: every gated read is isolated |
| ext_data | input | 8 | External data bus |
| status_data | input | 8 | Audio status register value |
| pad1_data | input | 8 | Joypad 1 read value |
| pad2_data | input | 8 | Joypad 2 read value |
| test_data | input | 8 | Test register value |
| int_addr | output | 16 | Internal address bus |
| pad1_clk | output | 1 | Joypad 1 clock strobe |
| pad2_clk | output | 1 | Joypad 2 clock strobe |
| isolate | output | 1 | Internal data bus cut off from external bus |
| reg_read | output | 1 | An on-chip register read takes place |
| bus_conflict | output | 1 | Joypad read overlaps external drive |
| rd_data | output | 8 | Byte returned on the internal data bus |
| open_bus | output | 8 | External open-bus latch |

## Verification
The sweep covers every low-address index, with test mode both off and on, for each of the three bus owners. The core address is placed both inside and outside the register window. This separates decoding on the core address from decoding on the internal address: a DMA index combined with a core address in the window must act, while the same index with the core address elsewhere must not. Each pattern is repeated with reads and non-reads, and the external byte changes every step. This shows whether the open-bus latch follows non-isolated reads only, and whether conflict data is the AND of the two sources rather than either source alone.

// File: rtl/apu_rd_pkg.sv
package apu_rd_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 5;

  localparam logic [IDX_W-1:0] IDX_STATUS = 5'h15;
  localparam logic [IDX_W-1:0] IDX_PAD1   = 5'h16;
  localparam logic [IDX_W-1:0] IDX_PAD2   = 5'h17;

  typedef enum logic [1:0] {
    SRC_CORE = 2'd0,
    SRC_OAM  = 2'd1,
    SRC_DMC  = 2'd2
  } bus_src_e;

  typedef struct packed {
    logic gate;
    logic isolate;
    logic conflict;
    logic pad1;
    logic pad2;
  } dec_t;
endpackage

// File: rtl/apu_addr_mux.sv
module apu_addr_mux #(
  parameter int AW = 16
) (
  input  logic          oam_gnt,
  input  logic          dmc_gnt,
  input  logic [AW-1:0] core_addr,
  input  logic [AW-1:0] oam_addr,
  input  logic [AW-1:0] dmc_addr,
  output logic [AW-1:0] int_addr
);
  import apu_rd_pkg::*;

  bus_src_e src;

  // Sample DMA outranks object DMA, which outranks the core.
  always_comb begin
    if (dmc_gnt)      src = SRC_DMC;
    else if (oam_gnt) src = SRC_OAM;
    else              src = SRC_CORE;
  end

  always_comb begin
    unique case (src)
      SRC_DMC: int_addr = dmc_addr;
      SRC_OAM: int_addr = oam_addr;
      default: int_addr = core_addr;
    endcase
  end
endmodule

// File: rtl/apu_rd_gate.sv
module apu_rd_gate #(
  parameter int              AW       = 16,
  parameter int              IW       = 5,
  parameter logic [AW-1:0]   REG_BASE = 16'h4000
) (
  input  logic              bus_rd,
  input  logic [AW-IW-1:0]  core_hi,
  input  logic [IW-1:0]     idx,
  input  logic              test_en,
  output apu_rd_pkg::dec_t  dec
);
  import apu_rd_pkg::*;

  localparam logic [AW-IW-1:0] WIN_TAG = REG_BASE[AW-1:IW];

  logic is_pad;

  always_comb begin
    dec      = '0;
    dec.gate = bus_rd && (core_hi == WIN_TAG);
    is_pad   = (idx == IDX_PAD1) || (idx == IDX_PAD2);
    if (dec.gate) begin
      dec.pad1     = (idx == IDX_PAD1);
      dec.pad2     = (idx == IDX_PAD2);
      dec.isolate  = (idx == IDX_STATUS) || test_en;
      dec.conflict = is_pad && !test_en;
    end
  end
endmodule

// File: rtl/apu_data_steer.sv
module apu_data_steer #(
  parameter int DW = 8,
  parameter int IW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  apu_rd_pkg::dec_t dec,
  input  logic [IW-1:0]    idx,
  input  logic [DW-1:0]    ext_data,
  input  logic [DW-1:0]    status_data,
  input  logic [DW-1:0]    pad1_data,
  input  logic [DW-1:0]    pad2_data,
  input  logic [DW-1:0]    test_data,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    open_bus
);
  import apu_rd_pkg::*;

  logic [DW-1:0] reg_val;
  logic [DW-1:0] pad_val;

  always_comb begin
    unique case (idx)
      IDX_STATUS: reg_val = status_data;
      IDX_PAD1:   reg_val = pad1_data;
      IDX_PAD2:   reg_val = pad2_data;
      default:    reg_val = test_data;
    endcase
    pad_val = dec.pad2 ? pad2_data : pad1_data;
  end

  always_comb begin
    if (dec.isolate)       rd_data = reg_val;
    else if (dec.conflict) rd_data = pad_val & ext_data;
    else                   rd_data = ext_data;
  end

  // The external latch sees only bus cycles that reach the pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     open_bus <= '0;
    else if (bus_rd && !dec.isolate) open_bus <= ext_data;
  end
endmodule

// File: rtl/apu_rd_decode.sv
module apu_rd_decode #(
  parameter int            AW       = apu_rd_pkg::ADDR_W,
  parameter int            DW       = apu_rd_pkg::DATA_W,
  parameter int            IW       = apu_rd_pkg::IDX_W,
  parameter logic [AW-1:0] REG_BASE = 16'h4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic [AW-1:0] core_addr,
  input  logic          oam_gnt,
  input  logic [AW-1:0] oam_addr,
  input  logic          dmc_gnt,
  input  logic [AW-1:0] dmc_addr,
  input  logic          test_en,
  input  logic [DW-1:0] ext_data,
  input  logic [DW-1:0] status_data,
  input  logic [DW-1:0] pad1_data,
  input  logic [DW-1:0] pad2_data,
  input  logic [DW-1:0] test_data,
  output logic [AW-1:0] int_addr,
  output logic          pad1_clk,
  output logic          pad2_clk,
  output logic          isolate,
  output logic          reg_read,
  output logic          bus_conflict,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] open_bus
);
  import apu_rd_pkg::*;

  dec_t          dec;
  logic [IW-1:0] idx;

  apu_addr_mux #(.AW(AW)) u_mux (
    .oam_gnt   (oam_gnt),
    .dmc_gnt   (dmc_gnt),
    .core_addr (core_addr),
    .oam_addr  (oam_addr),
    .dmc_addr  (dmc_addr),
    .int_addr  (int_addr)
  );

  assign idx = int_addr[IW-1:0];

  apu_rd_gate #(.AW(AW), .IW(IW), .REG_BASE(REG_BASE)) u_gate (
    .bus_rd  (bus_rd),
    .core_hi (core_addr[AW-1:IW]),
    .idx     (idx),
    .test_en (test_en),
    .dec     (dec)
  );

  apu_data_steer #(.DW(DW), .IW(IW)) u_steer (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .dec         (dec),
    .idx         (idx),
    .ext_data    (ext_data),
    .status_data (status_data),
    .pad1_data   (pad1_data),
    .pad2_data   (pad2_data),
    .test_data   (test_data),
    .rd_data     (rd_data),
    .open_bus    (open_bus)
  );

  assign pad1_clk     = dec.pad1;
  assign pad2_clk     = dec.pad2;
  assign isolate      = dec.isolate;
  assign bus_conflict = dec.conflict;
  assign reg_read     = dec.isolate | dec.conflict;
endmodule

// File: rtl/apu_rd_decode_chk.sv
module apu_rd_decode_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic [AW-1:0] core_addr,
  input logic          dmc_gnt,
  input logic [AW-1:0] dmc_addr,
  input logic [DW-1:0] ext_data,
  input logic [DW-1:0] pad1_data,
  input logic [DW-1:0] pad2_data,
  input logic [AW-1:0] int_addr,
  input logic          pad1_clk,
  input logic          pad2_clk,
  input logic          isolate,
  input logic          reg_read,
  input logic          bus_conflict,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] open_bus
);
  // R1
  dmc_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmc_gnt |-> int_addr == dmc_addr);

  // R2
  closed_gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && core_addr[15:5] == 11'h200) |->
      !(reg_read || isolate || bus_conflict || pad1_clk || pad2_clk));

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pad1_clk, pad2_clk}));

  // R6
  conflict_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_conflict |-> !isolate &&
      rd_data == (ext_data & (pad1_clk ? pad1_data : pad2_data)));

  // R8
  isolated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && isolate) |=> $stable(open_bus));

  // R8
  open_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !isolate) |=> open_bus == $past(ext_data));
endmodule

bind apu_rd_decode apu_rd_decode_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_apu_rd_decode.sv
module tb_apu_rd_decode;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_rd = 0, oam_gnt = 0, dmc_gnt = 0, test_en = 0;
  logic [15:0] core_addr = 0, oam_addr = 0, dmc_addr = 0;
  logic [7:0]  ext_data = 0, status_data = 8'hA5, pad1_data = 8'h3C;
  logic [7:0]  pad2_data = 8'hC6, test_data = 8'h5A;
  logic [15:0] int_addr;
  logic        pad1_clk, pad2_clk, isolate, reg_read, bus_conflict;
  logic [7:0]  rd_data, open_bus;

  int checks = 0, fails = 0;

  apu_rd_decode dut (.*);

  always #5 clk = ~clk;

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    logic [7:0] ob_exp;
    #1;
    chk("R8 reset open_bus", 16'(open_bus), 16'h0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    ob_exp = 8'h00;
    for (int src = 0; src < 3; src++)
      for (int inr = 0; inr < 2; inr++)
        for (int t = 0; t < 2; t++)
          for (int rd = 0; rd < 2; rd++)
            for (int idx = 0; idx < 32; idx++) begin
              logic [15:0] ia;
              logic gate, e_iso, e_cf, e_p1, e_p2;
              logic [7:0] e_rd, rv;
              @(negedge clk);
              chk("R8 open_bus", 16'(open_bus), 16'(ob_exp));
              bus_rd   = rd[0];
              test_en  = t[0];
              dmc_gnt  = (src == 2);
              oam_gnt  = (src >= 1);
              ext_data = 8'(idx * 37 + src * 11 + t * 5 + inr * 3 + 1);
              oam_addr = 16'h4000 | 16'(idx) | 16'h0040;
              dmc_addr = 16'h4000 | 16'(idx) | 16'h0080;
              if (src == 0) core_addr = (inr != 0) ? (16'h4000 | 16'(idx)) : (16'h8000 | 16'(idx));
              else          core_addr = (inr != 0) ? 16'h401F : 16'hC000 | 16'(31 - idx);
              #1;
              ia = (src == 2) ? dmc_addr : (src == 1) ? oam_addr : core_addr;
              gate  = rd[0] && (inr != 0);
              e_iso = gate && (idx == 'h15 || t != 0);
              e_p1  = gate && idx == 'h16;
              e_p2  = gate && idx == 'h17;
              e_cf  = gate && t == 0 && (idx == 'h16 || idx == 'h17);
              rv = (idx == 'h15) ? status_data : (idx == 'h16) ? pad1_data :
                   (idx == 'h17) ? pad2_data : test_data;
              e_rd = e_iso ? rv : e_cf ? (ext_data & (e_p1 ? pad1_data : pad2_data)) : ext_data;
              chk("R1 int_addr", int_addr, ia);
              chk("R3 R4 pad1_clk", 16'(pad1_clk), 16'(e_p1));
              chk("R4 pad2_clk", 16'(pad2_clk), 16'(e_p2));
              chk(gate ? "R5 isolate" : "R2 isolate", 16'(isolate), 16'(e_iso));
              chk("R6 bus_conflict", 16'(bus_conflict), 16'(e_cf));
              chk("R9 reg_read", 16'(reg_read), 16'(e_iso | e_cf));
              chk(e_iso ? "R5 rd_data" : e_cf ? "R6 rd_data" : "R7 rd_data",
                  16'(rd_data), 16'(e_rd));
              if (rd != 0 && !e_iso) ob_exp = ext_data;
            end
    @(negedge clk);
    chk("R8 final open_bus", 16'(open_bus), 16'(ob_exp));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule